// File: doc/BRIEF.md
# Power Supervisor and Fault Sequencer

This block decides when a flyback switching stage may run. Its inputs are single-bit flags from analog comparators. Three of them track the supply against three rising thresholds: a start level, a lower level below which switching must stop, and a still lower level below which the controller counts as fully unpowered. Further flags report supply over-voltage, a feedback node held above its open-loop limit, an output over-voltage sampled after each switch turn-off, and an over-temperature condition. The outputs are a switching enable, an enable for the high-voltage startup current source, the sequencer state and the cause of the most recent fault.

Undervoltage lockout is hysteretic. The controller starts once the supply passes the start level. Switching then continues down to the stop level, and the controller is fully reset only below the shutdown level. Feedback and supply over-voltage faults must persist for a programmable number of cycles before they act. Such a fault stops switching and waits for the supply to collapse past the shutdown level, and the part then recharges and tries again. This retry repeats for as long as the fault remains. An output over-voltage that persists locks switching off until the supply falls past the shutdown level, which stands for removal of input power. Over-temperature blanks the enable while its flag is raised and leaves the sequence alone. Every flag passes through a synchronizer of SYNC_STAGES flops before it is used.

Top module: `pwr_supervisor`

## Requirements
- R1: While reset is held and after it is released, state_o reads 0 (off), hv_src_en_o is 1, pwm_en_o is 0 and cause_o is 0 (none).
- R2: Off (0) moves to charging (1) once the shutdown-level flag is high. Charging falls back to off when that flag drops. hv_src_en_o is 1 only in the off and charging states.
- R3: Charging moves to running (2) on the start-level flag, and cause_o then reads 0. pwm_en_o can be 1 only while running. If the start-level flag drops while running, nothing changes.
- R4: While running, a low stop-level flag moves the state to auto-recover (3) with cause_o 1 (undervoltage). Auto-recover holds until the shutdown-level flag is low, and the state then becomes off.
- R5: A feedback-high flag seen on FB_DEB consecutive synchronized cycles while running moves the state to auto-recover with cause_o 2. A shorter burst restarts the count and has no effect.
- R6: A supply over-voltage flag seen on VOVP_DEB consecutive cycles while running moves the state to auto-recover with cause_o 3. The state stays there after the flag clears.
- R7: An output over-voltage flag seen on DOVP_DEB consecutive cycles while running moves the state to latched (4) with cause_o 4. Neither the stop-level flag nor the start-level flag can release it. Only a low shutdown-level flag returns it to off.
- R8: While the over-temperature flag is high, pwm_en_o is 0 and overtemp_o is 1, and the state stays as it was. Switching resumes when the flag clears.
- R9: Debounce counters are held at zero outside the running state. After a restart with the feedback fault still present, the fault fires exactly FB_DEB cycles after running is entered.
- R10: A flag change takes SYNC_STAGES cycles to reach the sequencer, so the state changes on the following edge. Over-temperature reaches pwm_en_o after SYNC_STAGES edges.
- R11: If the shutdown-level flag drops while running, the state goes directly to off with cause_o 1. Among simultaneous events in the running state, loss of supply wins, then output over-voltage, then the stop level, then supply over-voltage, then feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_start_i | input | 1 | Supply above the start level |
| vdd_pwm_ok_i | input | 1 | Supply above the switching-stop level |
| vdd_alive_i | input | 1 | Supply above the full-shutdown level |
| vdd_ovp_i | input | 1 | Supply above its over-voltage level |
| fb_high_i | input | 1 | Feedback above its open-loop threshold |
| det_ovp_i | input | 1 | Output over-voltage sampled after turn-off |
| overtemp_i | input | 1 | Die over-temperature (hysteresis applied upstream) |
| pwm_en_o | output | 1 | Switching enable |
| hv_src_en_o | output | 1 | Startup current source enable |
| state_o | output | 3 | 0 off, 1 charging, 2 running, 3 auto-recover, 4 latched |
| cause_o | output | 3 | 0 none, 1 undervoltage, 2 feedback, 3 supply OVP, 4 output OVP |
| overtemp_o | output | 1 | Synchronized over-temperature status |

## Verification
The hardest case to reach is a feedback fault that is still present when the part restarts. The retry has to re-arm its debounce at the moment running is entered, and not when the flag first rose during charging. The stimulus holds the feedback flag high through a complete supply collapse and recharge, then counts edges from the entry into running to the fault. A second difficult case is a burst one cycle shorter than the debounce length. The bench drops the flag exactly one edge before the count would complete, allowing for the synchronizer delay, and then confirms that the state is still running.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_CHARGE   = 3'd1,
        PS_RUN      = 3'd2,
        PS_RECOVER  = 3'd3,
        PS_LATCHED  = 3'd4
    } psup_state_e;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_UVLO = 3'd1,
        FC_FB   = 3'd2,
        FC_VOVP = 3'd3,
        FC_DOVP = 3'd4
    } psup_cause_e;

    typedef struct packed {
        logic vdd_start;
        logic vdd_pwm_ok;
        logic vdd_alive;
        logic vdd_ovp;
        logic fb_high;
        logic det_ovp;
        logic overtemp;
    } psup_flags_t;

    localparam int unsigned FLAG_W = $bits(psup_flags_t);

    localparam int unsigned NUM_DEB = 3;
    localparam int unsigned DEB_FB   = 0;
    localparam int unsigned DEB_VOVP = 1;
    localparam int unsigned DEB_DOVP = 2;

    function automatic logic src_on(psup_state_e s);
        return (s == PS_OFF) || (s == PS_CHARGE);
    endfunction

    function automatic logic sw_allowed(psup_state_e s, logic hot);
        return (s == PS_RUN) && !hot;
    endfunction

endpackage

// File: rtl/psup_sync.sv
module psup_sync #(
    parameter int unsigned WIDTH  = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] pipe_q [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        pipe_q[i] <= '0;
                    end else if (i == 0) begin
                        pipe_q[i] <= d;
                    end else begin
                        pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
                    end
                end
            end
            assign q = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/psup_debounce.sv
module psup_debounce #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flag,
    output logic fire
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    // fires on the LEN-th consecutive cycle that sees the flag
    assign fire = flag && !clr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !flag) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/psup_fsm.sv
module psup_fsm
    import pwr_sup_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  psup_flags_t flg,
    input  logic        fire_fb,
    input  logic        fire_vovp,
    input  logic        fire_dovp,
    output psup_state_e state_q,
    output psup_cause_e cause_q,
    output logic        deb_clr
);
    psup_state_e state_d;
    psup_cause_e cause_d;

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            PS_OFF: begin
                if (flg.vdd_alive) state_d = PS_CHARGE;
            end
            PS_CHARGE: begin
                if (!flg.vdd_alive) begin
                    state_d = PS_OFF;
                end else if (flg.vdd_start) begin
                    state_d = PS_RUN;
                    cause_d = FC_NONE;
                end
            end
            PS_RUN: begin
                if (!flg.vdd_alive) begin
                    state_d = PS_OFF;
                    cause_d = FC_UVLO;
                end else if (fire_dovp) begin
                    state_d = PS_LATCHED;
                    cause_d = FC_DOVP;
                end else if (!flg.vdd_pwm_ok) begin
                    state_d = PS_RECOVER;
                    cause_d = FC_UVLO;
                end else if (fire_vovp) begin
                    state_d = PS_RECOVER;
                    cause_d = FC_VOVP;
                end else if (fire_fb) begin
                    state_d = PS_RECOVER;
                    cause_d = FC_FB;
                end
            end
            PS_RECOVER, PS_LATCHED: begin
                if (!flg.vdd_alive) state_d = PS_OFF;
            end
            default: begin
                state_d = PS_OFF;
                cause_d = FC_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_OFF;
            cause_q <= FC_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    assign deb_clr = (state_q != PS_RUN);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FB_DEB      = 64,
    parameter int unsigned VOVP_DEB    = 16,
    parameter int unsigned DOVP_DEB    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vdd_start_i,
    input  logic       vdd_pwm_ok_i,
    input  logic       vdd_alive_i,
    input  logic       vdd_ovp_i,
    input  logic       fb_high_i,
    input  logic       det_ovp_i,
    input  logic       overtemp_i,
    output logic       pwm_en_o,
    output logic       hv_src_en_o,
    output logic [2:0] state_o,
    output logic [2:0] cause_o,
    output logic       overtemp_o
);
    localparam int unsigned DEB_LEN [NUM_DEB] = '{FB_DEB, VOVP_DEB, DOVP_DEB};

    psup_flags_t raw_flags;
    psup_flags_t syn_flags;
    logic [NUM_DEB-1:0] deb_in;
    logic [NUM_DEB-1:0] deb_fire;
    logic               deb_clr;
    psup_state_e        state_q;
    psup_cause_e        cause_q;

    assign raw_flags = '{
        vdd_start:  vdd_start_i,
        vdd_pwm_ok: vdd_pwm_ok_i,
        vdd_alive:  vdd_alive_i,
        vdd_ovp:    vdd_ovp_i,
        fb_high:    fb_high_i,
        det_ovp:    det_ovp_i,
        overtemp:   overtemp_i
    };

    psup_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_flags),
        .q   (syn_flags)
    );

    assign deb_in[DEB_FB]   = syn_flags.fb_high;
    assign deb_in[DEB_VOVP] = syn_flags.vdd_ovp;
    assign deb_in[DEB_DOVP] = syn_flags.det_ovp;

    generate
        for (genvar g = 0; g < NUM_DEB; g++) begin : g_deb
            psup_debounce #(.LEN(DEB_LEN[g])) u_deb (
                .clk  (clk),
                .rst  (rst),
                .clr  (deb_clr),
                .flag (deb_in[g]),
                .fire (deb_fire[g])
            );
        end
    endgenerate

    psup_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .flg       (syn_flags),
        .fire_fb   (deb_fire[DEB_FB]),
        .fire_vovp (deb_fire[DEB_VOVP]),
        .fire_dovp (deb_fire[DEB_DOVP]),
        .state_q   (state_q),
        .cause_q   (cause_q),
        .deb_clr   (deb_clr)
    );

    assign pwm_en_o    = sw_allowed(state_q, syn_flags.overtemp);
    assign hv_src_en_o = src_on(state_q);
    assign state_o     = state_q;
    assign cause_o     = cause_q;
    assign overtemp_o  = syn_flags.overtemp;
endmodule

// File: rtl/psup_checker.sv
module psup_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwm_en_o,
    input logic       hv_src_en_o,
    input logic [2:0] state_o,
    input logic [2:0] cause_o
);
    // R2: off may only stay or advance to charging
    a_r2_off_exit: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1));

    // R3: running is entered only from charging, with the cause cleared
    a_r3_run_entry: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && $past(state_o) != 3'd2)
            |-> ($past(state_o) == 3'd1 && cause_o == 3'd0));

    // R3: switching never enabled outside running, never with startup source
    a_r3_pwm_only_run: assert property (@(posedge clk) disable iff (rst)
        pwm_en_o |-> (state_o == 3'd2 && !hv_src_en_o));

    // R4: auto-recover leaves only toward off
    a_r4_recover_exit: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3) |=> (state_o == 3'd3 || state_o == 3'd0));

    // R7: latched leaves only toward off, entered only from running
    a_r7_latch_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4) |=> (state_o == 3'd4 || state_o == 3'd0));

    a_r7_latch_entry: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && $past(state_o) != 3'd4)
            |-> ($past(state_o) == 3'd2 && cause_o == 3'd4));

    // R6: a recorded fault cause stays put while in a fault state
    a_r6_cause_hold: assert property (@(posedge clk) disable iff (rst)
        ((state_o == 3'd3 || state_o == 3'd4) && $past(state_o) == state_o)
            |-> $stable(cause_o));
endmodule

bind pwr_supervisor psup_checker u_psup_checker (
    .clk         (clk),
    .rst         (rst),
    .pwm_en_o    (pwm_en_o),
    .hv_src_en_o (hv_src_en_o),
    .state_o     (state_o),
    .cause_o     (cause_o)
);

// File: tb/tb_pwr_supervisor.sv
module tb_pwr_supervisor;

    localparam int SYNC = 2;
    localparam int FBL  = 20;
    localparam int VOL  = 6;
    localparam int DOL  = 5;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vdd_start_i = 0, vdd_pwm_ok_i = 0, vdd_alive_i = 0, vdd_ovp_i = 0;
    logic fb_high_i = 0, det_ovp_i = 0, overtemp_i = 0;
    logic pwm_en_o, hv_src_en_o, overtemp_o;
    logic [2:0] state_o, cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_supervisor #(
        .SYNC_STAGES(SYNC), .FB_DEB(FBL), .VOVP_DEB(VOL), .DOVP_DEB(DOL)
    ) dut (
        .clk(clk), .rst(rst),
        .vdd_start_i(vdd_start_i), .vdd_pwm_ok_i(vdd_pwm_ok_i),
        .vdd_alive_i(vdd_alive_i), .vdd_ovp_i(vdd_ovp_i),
        .fb_high_i(fb_high_i), .det_ovp_i(det_ovp_i), .overtemp_i(overtemp_i),
        .pwm_en_o(pwm_en_o), .hv_src_en_o(hv_src_en_o),
        .state_o(state_o), .cause_o(cause_o), .overtemp_o(overtemp_o)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_st(string rid, int st, bit pwm, bit hv);
        checks++;
        if (state_o !== 3'(st) || pwm_en_o !== pwm || hv_src_en_o !== hv) begin
            errors++;
            $display("FAIL %s: state/pwm/hv = %0d/%0b/%0b, expected %0d/%0b/%0b",
                     rid, state_o, pwm_en_o, hv_src_en_o, st, pwm, hv);
        end
    endtask

    task automatic expect_cause(string rid, int c);
        checks++;
        if (cause_o !== 3'(c)) begin
            errors++;
            $display("FAIL %s: cause = %0d, expected %0d", rid, cause_o, c);
        end
    endtask

    task automatic power_up();
        vdd_alive_i = 1;
        step(LAT);
        expect_st("R2", 1, 0, 1);
        vdd_pwm_ok_i = 1;
        vdd_start_i = 1;
        step(LAT);
        expect_st("R3", 2, 1, 0);
        expect_cause("R3", 0);
    endtask

    task automatic power_down();
        vdd_start_i = 0;
        vdd_pwm_ok_i = 0;
        vdd_alive_i = 0;
        step(LAT);
        expect_st("R4", 0, 0, 1);
    endtask

    task automatic t_reset();
        rst = 1;
        step(2);
        expect_st("R1", 0, 0, 1);
        expect_cause("R1", 0);
        rst = 0;
        step(3);
        expect_st("R1", 0, 0, 1);
        expect_cause("R1", 0);
    endtask

    task automatic t_startup();
        vdd_alive_i = 1;
        step(LAT - 1);
        expect_st("R10", 0, 0, 1);
        step(1);
        expect_st("R2", 1, 0, 1);
        vdd_pwm_ok_i = 1;
        step(LAT + 4);
        expect_st("R3", 1, 0, 1);
        vdd_alive_i = 0;
        step(LAT);
        expect_st("R2", 0, 0, 1);
        vdd_alive_i = 1;
        step(LAT);
        vdd_start_i = 1;
        step(LAT);
        expect_st("R3", 2, 1, 0);
        vdd_start_i = 0;
        step(6);
        expect_st("R3", 2, 1, 0);
    endtask

    task automatic t_uvlo();
        vdd_pwm_ok_i = 0;
        step(LAT);
        expect_st("R4", 3, 0, 0);
        expect_cause("R4", 1);
        vdd_pwm_ok_i = 1;
        vdd_start_i = 1;
        step(6);
        expect_st("R4", 3, 0, 0);
        power_down();
    endtask

    task automatic t_supply_loss();
        power_up();
        vdd_alive_i = 0;
        vdd_pwm_ok_i = 0;
        vdd_ovp_i = 0;
        step(LAT);
        expect_st("R11", 0, 0, 1);
        expect_cause("R11", 1);
        vdd_start_i = 0;
        step(2);
    endtask

    task automatic t_feedback();
        power_up();
        fb_high_i = 1;
        step(FBL - 1);
        fb_high_i = 0;
        step(LAT + 5);
        expect_st("R5", 2, 1, 0);
        fb_high_i = 1;
        step(SYNC + FBL - 1);
        expect_st("R5", 2, 1, 0);
        step(1);
        expect_st("R5", 3, 0, 0);
        expect_cause("R5", 2);
        power_down();
        // retry with the fault still present
        power_up();
        step(FBL - 1);
        expect_st("R9", 2, 1, 0);
        step(1);
        expect_st("R9", 3, 0, 0);
        expect_cause("R9", 2);
        fb_high_i = 0;
        power_down();
    endtask

    task automatic t_supply_ovp();
        power_up();
        vdd_ovp_i = 1;
        step(SYNC + VOL - 1);
        expect_st("R6", 2, 1, 0);
        step(1);
        expect_st("R6", 3, 0, 0);
        expect_cause("R6", 3);
        vdd_ovp_i = 0;
        step(10);
        expect_st("R6", 3, 0, 0);
        power_down();
    endtask

    task automatic t_output_ovp();
        power_up();
        det_ovp_i = 1;
        step(SYNC + DOL - 1);
        expect_st("R7", 2, 1, 0);
        step(1);
        expect_st("R7", 4, 0, 0);
        expect_cause("R7", 4);
        det_ovp_i = 0;
        vdd_pwm_ok_i = 0;
        vdd_start_i = 0;
        step(10);
        expect_st("R7", 4, 0, 0);
        vdd_pwm_ok_i = 1;
        vdd_start_i = 1;
        step(LAT + 2);
        expect_st("R7", 4, 0, 0);
        expect_cause("R7", 4);
        vdd_start_i = 0;
        vdd_pwm_ok_i = 0;
        vdd_alive_i = 0;
        step(LAT);
        expect_st("R7", 0, 0, 1);
        power_up();
    endtask

    task automatic t_overtemp();
        overtemp_i = 1;
        step(SYNC - 1);
        expect_st("R10", 2, 1, 0);
        step(1);
        expect_st("R8", 2, 0, 0);
        checks++;
        if (overtemp_o !== 1'b1) begin
            errors++;
            $display("FAIL R8: overtemp_o = %0b, expected 1", overtemp_o);
        end
        step(8);
        expect_st("R8", 2, 0, 0);
        overtemp_i = 0;
        step(SYNC);
        expect_st("R8", 2, 1, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_startup();
        t_uvlo();
        t_supply_loss();
        t_feedback();
        t_supply_ovp();
        t_output_ovp();
        t_overtemp();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule